// File: doc/BRIEF.md
# Exception Entry and Vector Unit

This unit accepts one exception event per cycle from the pipeline and commits every piece of control-register state the event touches. The new fetch address, the cause code, the saved return address and the status bits all change together on the same clock edge. The handler address depends on the event kind, on the exception-level, error-level and boot-vector status bits, on the interrupt vectoring configuration and on whether the event is a TLB refill. The saved return address steps back one instruction when the faulting instruction sits in a branch delay slot.

Address-translation faults also record the faulting virtual address. They load its page-number bits into the page-table context register and into the translation-entry high register, which keeps the current address-space identifier. A return-from-handler pulse clears the error level if it is set, and otherwise clears the exception level. Reset clears all state. The boot-vector bit resets to the value of a parameter, which defaults to 0.

Top module: `exc_entry`

## Requirements
- R1: `cause_o` places the exception code in bits 6:2, the delay flag in bit 31 and the coprocessor number in bits 29:28. Kind codes on `exc_kind_i` are 0 intr, 1 tlb_miss, 2 tlb_inv, 3 tlb_dirty, 4 addr_err, 5 ibe, 6 dbe, 7 sys, 8 bp, 9 ri, 10 cpu, 11 ov, 12 tr, 13 fpe, 14 c2e, 15 mdmx, 16 watch, 17 mcheck, 18 thread, 19 dspdis, 20 cache, 21 nmi and 22 soft_reset. These write the codes 0, -, -, 1, -, 6, 7, 8, 9, 10, 11, 12, 13, 15, 18, 22, 23, 24, 25, 26 and 30, in that order. Kinds 23 to 31 are ignored: there is no redirect and no state change.
- R2: A TLB miss or invalid-entry fault writes code 2 for a load (`store_i`=0) and 3 for a store. A dirty fault writes code 1 in either direction. An address error writes 4 for a load and 5 for a store.
- R3: The vector base is 0xBFC00200 when BEV is set, and otherwise `ebase_i` with bits 9:0 cleared. The default offset is 0x180.
- R4: A TLB miss taken while EXL is clear uses offset 0x000. Taken while EXL is set, it uses 0x180.
- R5: When `vint_i`=0, an interrupt uses offset 0x200 if `iv_i` is set and 0x180 if it is not. When `vint_i`=1, the offset is 0x200 + v*(`vs_i`*32). Here v is the highest set bit, from 7 down to 1, of `irq_pend_i & irq_mask_i`, or 0 if none of those bits is set.
- R6: For an ordinary exception taken while EXL is clear, EPC becomes `pc_i`, or `pc_i`-4 when `delay_slot_i` is set, BD follows `delay_slot_i`, and EXL is set. While EXL is set, EPC and BD hold.
- R7: NMI and soft reset redirect to 0xBFC00000. They save the return PC (with the same delay-slot adjustment) to ErrorEPC and set ERL and BEV. NMI sets `nmi_o` and soft reset sets `sr_o`. BD is cleared if EXL is clear. The exception code is unchanged.
- R8: A coprocessor-unusable exception writes `cop_num_i` into the CE field. Other kinds leave CE unchanged.
- R9: TLB and address faults write BadVAddr to `bad_addr_i`. They replace context bits 22:4 with address bits 31:13, and set EntryHi to address bits 31:13 in bits 31:13 and `asid_i` in bits 7:0. Other kinds leave these registers unchanged.
- R10: A cache error uses offset 0x100 with BEV set, and otherwise offset 0x20000100 from the EBase-derived base.
- R11: Entry takes one cycle. All outputs update on the edge that samples `exc_valid_i`, and `redirect_o` is high for exactly that following cycle. `eret_i` clears ERL if it is set and otherwise clears EXL. `eret_i` is ignored in a cycle that takes an exception.
- R12: After reset every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| exc_valid_i | input | 1 | Exception event this cycle |
| exc_kind_i | input | 5 | Event kind (R1 encoding) |
| store_i | input | 1 | Faulting access was a store |
| pc_i | input | 32 | Faulting instruction address |
| delay_slot_i | input | 1 | Faulting instruction is in a delay slot |
| bad_addr_i | input | 32 | Faulting virtual address |
| cop_num_i | input | 2 | Coprocessor number for unusable fault |
| irq_pend_i | input | 8 | Pending interrupt lines |
| irq_mask_i | input | 8 | Interrupt mask bits |
| ebase_i | input | 32 | Exception base register |
| iv_i | input | 1 | Special interrupt vector enable |
| vint_i | input | 1 | Vectored interrupt mode |
| vs_i | input | 5 | Vector spacing field |
| asid_i | input | 8 | Current address-space identifier |
| eret_i | input | 1 | Return from handler |
| redirect_o | output | 1 | Fetch redirect pulse |
| pc_o | output | 32 | Handler entry address |
| cause_o | output | 32 | Cause register image |
| epc_o | output | 32 | Exception return address |
| error_epc_o | output | 32 | Error-level return address |
| exl_o | output | 1 | Exception level |
| erl_o | output | 1 | Error level |
| bev_o | output | 1 | Boot exception vectors |
| nmi_o | output | 1 | NMI status flag |
| sr_o | output | 1 | Soft-reset status flag |
| badvaddr_o | output | 32 | Faulting virtual address |
| context_o | output | 32 | Page-table context |
| entryhi_o | output | 32 | Translation entry high |

## Verification
The bound checker checks four things on every cycle. The one-cycle redirect pulse follows each accepted event and never occurs without one. EXL is set after any ordinary exception, and EPC holds when an exception arrives with EXL already set. The boot vector and error-level bits follow NMI and soft reset, and the system-call code lands in bits 6:2. Only the bench scenarios show the handler offsets under BEV, refill, interrupt spacing and cache error, the vector priority with masking, the load/store code selection, the delay-slot adjustment, the CE and translation-register writes, and that unknown kinds and a concurrent return are ignored.

// File: rtl/exc_pkg.sv
`timescale 1ns/1ps
package exc_pkg;
  typedef enum logic [4:0] {
    KIND_INTR      = 5'd0,
    KIND_TLB_MISS  = 5'd1,
    KIND_TLB_INV   = 5'd2,
    KIND_TLB_DIRTY = 5'd3,
    KIND_ADDR_ERR  = 5'd4,
    KIND_IBE       = 5'd5,
    KIND_DBE       = 5'd6,
    KIND_SYS       = 5'd7,
    KIND_BP        = 5'd8,
    KIND_RI        = 5'd9,
    KIND_CPU       = 5'd10,
    KIND_OV        = 5'd11,
    KIND_TR        = 5'd12,
    KIND_FPE       = 5'd13,
    KIND_C2E       = 5'd14,
    KIND_MDMX      = 5'd15,
    KIND_WATCH     = 5'd16,
    KIND_MCHECK    = 5'd17,
    KIND_THREAD    = 5'd18,
    KIND_DSPDIS    = 5'd19,
    KIND_CACHE     = 5'd20,
    KIND_NMI       = 5'd21,
    KIND_SRESET    = 5'd22
  } exc_kind_e;

  typedef struct packed {
    logic       known;
    logic [4:0] code;
    logic       mmu;
    logic       refill;
    logic       err_lvl;
    logic       nmi;
    logic       cpu;
    logic       cache;
    logic       intr;
  } exc_class_t;
endpackage

// File: rtl/exc_classify.sv
`timescale 1ns/1ps
module exc_classify
  import exc_pkg::*;
(
  input  logic [4:0] kind_i,
  input  logic       store_i,
  output exc_class_t cls_o
);
  always_comb begin
    cls_o       = '0;
    cls_o.known = 1'b1;
    case (exc_kind_e'(kind_i))
      KIND_INTR:      cls_o.intr = 1'b1;
      KIND_TLB_MISS:  begin cls_o.code = store_i ? 5'd3 : 5'd2; cls_o.mmu = 1'b1; cls_o.refill = 1'b1; end
      KIND_TLB_INV:   begin cls_o.code = store_i ? 5'd3 : 5'd2; cls_o.mmu = 1'b1; end
      KIND_TLB_DIRTY: begin cls_o.code = 5'd1; cls_o.mmu = 1'b1; end
      KIND_ADDR_ERR:  begin cls_o.code = store_i ? 5'd5 : 5'd4; cls_o.mmu = 1'b1; end
      KIND_IBE:       cls_o.code = 5'd6;
      KIND_DBE:       cls_o.code = 5'd7;
      KIND_SYS:       cls_o.code = 5'd8;
      KIND_BP:        cls_o.code = 5'd9;
      KIND_RI:        cls_o.code = 5'd10;
      KIND_CPU:       begin cls_o.code = 5'd11; cls_o.cpu = 1'b1; end
      KIND_OV:        cls_o.code = 5'd12;
      KIND_TR:        cls_o.code = 5'd13;
      KIND_FPE:       cls_o.code = 5'd15;
      KIND_C2E:       cls_o.code = 5'd18;
      KIND_MDMX:      cls_o.code = 5'd22;
      KIND_WATCH:     cls_o.code = 5'd23;
      KIND_MCHECK:    cls_o.code = 5'd24;
      KIND_THREAD:    cls_o.code = 5'd25;
      KIND_DSPDIS:    cls_o.code = 5'd26;
      KIND_CACHE:     begin cls_o.code = 5'd30; cls_o.cache = 1'b1; end
      KIND_NMI:       begin cls_o.err_lvl = 1'b1; cls_o.nmi = 1'b1; end
      KIND_SRESET:    cls_o.err_lvl = 1'b1;
      default:        cls_o.known = 1'b0;
    endcase
  end
endmodule

// File: rtl/exc_irq_prio.sv
`timescale 1ns/1ps
module exc_irq_prio #(
  parameter int IRQ_W = 8,
  localparam int VEC_W = $clog2(IRQ_W)
) (
  input  logic [IRQ_W-1:0] pend_i,
  input  logic [IRQ_W-1:0] mask_i,
  output logic [VEC_W-1:0] vec_o
);
  logic [IRQ_W-1:0] live;
  assign live = pend_i & mask_i;

  // line 0 never wins: it shares vector 0 with "nothing pending"
  always_comb begin
    vec_o = '0;
    for (int i = 1; i < IRQ_W; i++)
      if (live[i]) vec_o = VEC_W'(i);
  end
endmodule

// File: rtl/exc_vector.sv
`timescale 1ns/1ps
module exc_vector
  import exc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int VEC_W  = 3,
  parameter int VS_W   = 5
) (
  input  exc_class_t        cls_i,
  input  logic              bev_i,
  input  logic              exl_i,
  input  logic [ADDR_W-1:0] ebase_i,
  input  logic              iv_i,
  input  logic              vint_i,
  input  logic [VS_W-1:0]   vs_i,
  input  logic [VEC_W-1:0]  vec_i,
  output logic [ADDR_W-1:0] target_o
);
  localparam logic [ADDR_W-1:0] BOOT_VEC  = ADDR_W'(32'hBFC0_0000);
  localparam logic [ADDR_W-1:0] BEV_BASE  = ADDR_W'(32'hBFC0_0200);
  localparam logic [ADDR_W-1:0] OFF_GEN   = ADDR_W'(32'h180);
  localparam logic [ADDR_W-1:0] OFF_IRQ   = ADDR_W'(32'h200);
  localparam logic [ADDR_W-1:0] OFF_CBEV  = ADDR_W'(32'h100);
  localparam logic [ADDR_W-1:0] OFF_CACHE = ADDR_W'(32'h2000_0100);

  logic [ADDR_W-1:0] base, offset, spacing;

  assign base    = bev_i ? BEV_BASE : {ebase_i[ADDR_W-1:10], 10'b0};
  assign spacing = ADDR_W'(vs_i) << 5;

  always_comb begin
    if (cls_i.cache)                offset = bev_i ? OFF_CBEV : OFF_CACHE;
    else if (cls_i.refill && !exl_i) offset = '0;
    else if (cls_i.intr && vint_i)  offset = OFF_IRQ + ADDR_W'(vec_i) * spacing;
    else if (cls_i.intr && iv_i)    offset = OFF_IRQ;
    else                            offset = OFF_GEN;
  end

  assign target_o = cls_i.err_lvl ? BOOT_VEC : base + offset;
endmodule

// File: rtl/exc_state.sv
`timescale 1ns/1ps
module exc_state
  import exc_pkg::*;
#(
  parameter int   ADDR_W  = 32,
  parameter int   ASID_W  = 8,
  parameter logic BEV_RST = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  input  exc_class_t        cls_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic              dly_i,
  input  logic [ADDR_W-1:0] bad_i,
  input  logic [1:0]        cp_i,
  input  logic [ASID_W-1:0] asid_i,
  input  logic [ADDR_W-1:0] target_i,
  input  logic              eret_i,
  output logic              redirect_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic [4:0]        code_o,
  output logic              bd_o,
  output logic [1:0]        ce_o,
  output logic [ADDR_W-1:0] epc_o,
  output logic [ADDR_W-1:0] eepc_o,
  output logic              exl_o,
  output logic              erl_o,
  output logic              bev_o,
  output logic              nmi_o,
  output logic              sr_o,
  output logic [ADDR_W-1:0] bva_o,
  output logic [ADDR_W-1:0] ctx_o,
  output logic [ADDR_W-1:0] ehi_o
);
  localparam int VPN_LO = 13;
  localparam int CTX_LO = 4;
  localparam int CTX_HI = CTX_LO + (ADDR_W - VPN_LO) - 1;

  logic [ADDR_W-1:0] ret_pc;
  assign ret_pc = dly_i ? pc_i - ADDR_W'(4) : pc_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      redirect_o <= 1'b0;
      pc_o   <= '0;
      code_o <= '0;
      bd_o   <= 1'b0;
      ce_o   <= '0;
      epc_o  <= '0;
      eepc_o <= '0;
      exl_o  <= 1'b0;
      erl_o  <= 1'b0;
      bev_o  <= BEV_RST;
      nmi_o  <= 1'b0;
      sr_o   <= 1'b0;
      bva_o  <= '0;
      ctx_o  <= '0;
      ehi_o  <= '0;
    end else begin
      redirect_o <= take_i;
      if (take_i) begin
        pc_o <= target_i;
        if (cls_i.err_lvl) begin
          eepc_o <= ret_pc;
          erl_o  <= 1'b1;
          bev_o  <= 1'b1;
          if (cls_i.nmi) nmi_o <= 1'b1;
          else           sr_o  <= 1'b1;
          if (!exl_o) bd_o <= 1'b0;
        end else begin
          code_o <= cls_i.code;
          if (cls_i.cpu) ce_o <= cp_i;
          if (!exl_o) begin
            epc_o <= ret_pc;
            bd_o  <= dly_i;
            exl_o <= 1'b1;
          end
          if (cls_i.mmu) begin
            bva_o <= bad_i;
            ctx_o[CTX_HI:CTX_LO] <= bad_i[ADDR_W-1:VPN_LO];
            ehi_o <= {bad_i[ADDR_W-1:VPN_LO], {(VPN_LO-ASID_W){1'b0}}, asid_i};
          end
        end
      end else if (eret_i) begin
        if (erl_o) erl_o <= 1'b0;
        else       exl_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/exc_entry.sv
`timescale 1ns/1ps
module exc_entry
  import exc_pkg::*;
#(
  parameter int   ADDR_W  = 32,
  parameter int   ASID_W  = 8,
  parameter int   IRQ_W   = 8,
  parameter int   VS_W    = 5,
  parameter logic BEV_RST = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              exc_valid_i,
  input  logic [4:0]        exc_kind_i,
  input  logic              store_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic              delay_slot_i,
  input  logic [ADDR_W-1:0] bad_addr_i,
  input  logic [1:0]        cop_num_i,
  input  logic [IRQ_W-1:0]  irq_pend_i,
  input  logic [IRQ_W-1:0]  irq_mask_i,
  input  logic [ADDR_W-1:0] ebase_i,
  input  logic              iv_i,
  input  logic              vint_i,
  input  logic [VS_W-1:0]   vs_i,
  input  logic [ASID_W-1:0] asid_i,
  input  logic              eret_i,
  output logic              redirect_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic [31:0]       cause_o,
  output logic [ADDR_W-1:0] epc_o,
  output logic [ADDR_W-1:0] error_epc_o,
  output logic              exl_o,
  output logic              erl_o,
  output logic              bev_o,
  output logic              nmi_o,
  output logic              sr_o,
  output logic [ADDR_W-1:0] badvaddr_o,
  output logic [ADDR_W-1:0] context_o,
  output logic [ADDR_W-1:0] entryhi_o
);
  localparam int VEC_W = $clog2(IRQ_W);

  exc_class_t        cls;
  logic [VEC_W-1:0]  vec;
  logic [ADDR_W-1:0] target;
  logic              take;
  logic [4:0]        code;
  logic              bd;
  logic [1:0]        ce;

  exc_classify u_classify (.kind_i(exc_kind_i), .store_i(store_i), .cls_o(cls));

  exc_irq_prio #(.IRQ_W(IRQ_W)) u_prio (
    .pend_i(irq_pend_i), .mask_i(irq_mask_i), .vec_o(vec)
  );

  exc_vector #(.ADDR_W(ADDR_W), .VEC_W(VEC_W), .VS_W(VS_W)) u_vector (
    .cls_i(cls), .bev_i(bev_o), .exl_i(exl_o), .ebase_i(ebase_i),
    .iv_i(iv_i), .vint_i(vint_i), .vs_i(vs_i), .vec_i(vec), .target_o(target)
  );

  assign take = exc_valid_i && cls.known;

  exc_state #(.ADDR_W(ADDR_W), .ASID_W(ASID_W), .BEV_RST(BEV_RST)) u_state (
    .clk_i(clk_i), .rst_ni(rst_ni), .take_i(take), .cls_i(cls),
    .pc_i(pc_i), .dly_i(delay_slot_i), .bad_i(bad_addr_i), .cp_i(cop_num_i),
    .asid_i(asid_i), .target_i(target), .eret_i(eret_i),
    .redirect_o(redirect_o), .pc_o(pc_o), .code_o(code), .bd_o(bd), .ce_o(ce),
    .epc_o(epc_o), .eepc_o(error_epc_o), .exl_o(exl_o), .erl_o(erl_o),
    .bev_o(bev_o), .nmi_o(nmi_o), .sr_o(sr_o), .bva_o(badvaddr_o),
    .ctx_o(context_o), .ehi_o(entryhi_o)
  );

  assign cause_o = {bd, 1'b0, ce, 21'b0, code, 2'b0};
endmodule

// File: rtl/exc_entry_chk.sv
`timescale 1ns/1ps
module exc_entry_chk
  import exc_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        exc_valid_i,
  input logic [4:0]  exc_kind_i,
  input logic        redirect_o,
  input logic [31:0] pc_o,
  input logic [31:0] cause_o,
  input logic [31:0] epc_o,
  input logic        exl_o,
  input logic        erl_o,
  input logic        bev_o
);
  logic ordinary, boot;
  assign ordinary = exc_valid_i && (exc_kind_i <= 5'd20);
  assign boot     = exc_valid_i && (exc_kind_i == KIND_NMI || exc_kind_i == KIND_SRESET);

  a_r11_redirect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ordinary || boot) |=> redirect_o);
  a_r11_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exc_valid_i |=> !redirect_o);
  a_r6_exl_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ordinary |=> exl_o);
  a_r6_epc_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ordinary && exl_o) |=> $stable(epc_o));
  a_r7_boot_vec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boot |=> (pc_o == 32'hBFC0_0000 && erl_o && bev_o));
  a_r1_sys_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_valid_i && exc_kind_i == KIND_SYS) |=> cause_o[6:2] == 5'd8);
endmodule

bind exc_entry exc_entry_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .exc_valid_i(exc_valid_i), .exc_kind_i(exc_kind_i),
  .redirect_o(redirect_o), .pc_o(pc_o), .cause_o(cause_o), .epc_o(epc_o),
  .exl_o(exl_o), .erl_o(erl_o), .bev_o(bev_o)
);

// File: tb/exc_entry_bench.sv
`timescale 1ns/1ps
module exc_entry_bench;
  import exc_pkg::*;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        exc_valid = 1'b0, store = 1'b0, dly = 1'b0, iv = 1'b0, vint = 1'b0, eret = 1'b0;
  logic [4:0]  kind = '0, vs = '0;
  logic [31:0] pc = '0, bad = '0, ebase = 32'h8000_0000;
  logic [1:0]  cp = '0;
  logic [7:0]  pend = '0, mask = 8'hFF, asid = 8'h5A;

  logic        redirect_o, exl_o, erl_o, bev_o, nmi_o, sr_o;
  logic [31:0] pc_o, cause_o, epc_o, eepc_o, bva_o, ctx_o, ehi_o;

  exc_entry u_exc_entry (
    .clk_i(clk), .rst_ni(rst_n), .exc_valid_i(exc_valid), .exc_kind_i(kind),
    .store_i(store), .pc_i(pc), .delay_slot_i(dly), .bad_addr_i(bad), .cop_num_i(cp),
    .irq_pend_i(pend), .irq_mask_i(mask), .ebase_i(ebase), .iv_i(iv), .vint_i(vint),
    .vs_i(vs), .asid_i(asid), .eret_i(eret), .redirect_o(redirect_o), .pc_o(pc_o),
    .cause_o(cause_o), .epc_o(epc_o), .error_epc_o(eepc_o), .exl_o(exl_o),
    .erl_o(erl_o), .bev_o(bev_o), .nmi_o(nmi_o), .sr_o(sr_o), .badvaddr_o(bva_o),
    .context_o(ctx_o), .entryhi_o(ehi_o)
  );

  typedef struct {
    logic [31:0] pc, cause, epc, eepc, st, bva, ctx, ehi;
    string tag;
  } exp_t;
  exp_t sb[$];

  int n_chk = 0, n_fail = 0;

  // reference model of the architectural state
  logic        m_exl, m_erl, m_bev, m_nmi, m_sr, m_bd;
  logic [1:0]  m_ce;
  logic [4:0]  m_code;
  logic [31:0] m_epc, m_eepc, m_bva, m_ctx, m_ehi;

  task automatic model_reset();
    m_exl = 0; m_erl = 0; m_bev = 0; m_nmi = 0; m_sr = 0; m_bd = 0;
    m_ce = 0; m_code = 0; m_epc = 0; m_eepc = 0; m_bva = 0; m_ctx = 0; m_ehi = 0;
  endtask

  function automatic logic [31:0] m_cause();
    return {m_bd, 1'b0, m_ce, 21'b0, m_code, 2'b0};
  endfunction
  function automatic logic [31:0] m_st();
    return {27'b0, m_exl, m_erl, m_bev, m_nmi, m_sr};
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [4:0] code_of(exc_kind_e k, logic st);
    case (k)
      KIND_INTR: return 0;
      KIND_TLB_MISS, KIND_TLB_INV: return st ? 5'd3 : 5'd2;
      KIND_TLB_DIRTY: return 1;
      KIND_ADDR_ERR: return st ? 5'd5 : 5'd4;
      KIND_IBE: return 6;  KIND_DBE: return 7;  KIND_SYS: return 8;
      KIND_BP: return 9;   KIND_RI: return 10;  KIND_CPU: return 11;
      KIND_OV: return 12;  KIND_TR: return 13;  KIND_FPE: return 15;
      KIND_C2E: return 18; KIND_MDMX: return 22; KIND_WATCH: return 23;
      KIND_MCHECK: return 24; KIND_THREAD: return 25; KIND_DSPDIS: return 26;
      KIND_CACHE: return 30;
      default: return 0;
    endcase
  endfunction

  // drive one event, predict its effect, push the prediction
  task automatic fire(input exc_kind_e k, input logic st, input logic [31:0] fpc,
                      input logic d, input logic [31:0] fbad, input logic [1:0] fcp,
                      input logic with_eret, input string tag);
    exp_t e;
    logic [31:0] base, off, rpc;
    int v;
    @(negedge clk);
    exc_valid = 1; kind = k; store = st; pc = fpc; dly = d; bad = fbad; cp = fcp;
    eret = with_eret;
    base = m_bev ? 32'hBFC0_0200 : {ebase[31:10], 10'b0};
    rpc  = d ? fpc - 32'd4 : fpc;
    if (k == KIND_CACHE) off = m_bev ? 32'h100 : 32'h2000_0100;
    else if (k == KIND_TLB_MISS && !m_exl) off = 0;
    else if (k == KIND_INTR && vint) begin
      v = 0;
      for (int i = 7; i >= 1; i--) if ((pend[i] & mask[i]) && v == 0) v = i;
      off = 32'h200 + v * (vs * 32);
    end else if (k == KIND_INTR && iv) off = 32'h200;
    else off = 32'h180;
    if (k == KIND_NMI || k == KIND_SRESET) begin
      e.pc = 32'hBFC0_0000;
      m_eepc = rpc; m_erl = 1; m_bev = 1;
      if (k == KIND_NMI) m_nmi = 1; else m_sr = 1;
      if (!m_exl) m_bd = 0;
    end else begin
      e.pc = base + off;
      m_code = code_of(k, st);
      if (k == KIND_CPU) m_ce = fcp;
      if (!m_exl) begin m_epc = rpc; m_bd = d; m_exl = 1; end
      if (k inside {KIND_TLB_MISS, KIND_TLB_INV, KIND_TLB_DIRTY, KIND_ADDR_ERR}) begin
        m_bva = fbad;
        m_ctx = {9'b0, fbad[31:13], 4'b0};
        m_ehi = {fbad[31:13], 5'b0, asid};
      end
    end
    e.cause = m_cause(); e.epc = m_epc; e.eepc = m_eepc; e.st = m_st();
    e.bva = m_bva; e.ctx = m_ctx; e.ehi = m_ehi; e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
    exc_valid = 0; eret = 0;
  endtask

  task automatic do_eret(input string tag);
    @(negedge clk); eret = 1;
    if (m_erl) m_erl = 0; else m_exl = 0;
    @(negedge clk); eret = 0;
    chk(redirect_o == 0 && {exl_o, erl_o} == {m_exl, m_erl}, tag, "eret status",
        {30'b0, exl_o, erl_o}, {30'b0, m_exl, m_erl});
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; model_reset();
    repeat (2) @(negedge clk); rst_n = 1;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && redirect_o) begin
      if (sb.size() == 0) chk(0, "R11", "unexpected redirect", 1, 0);
      else begin
        exp_t e;
        e = sb.pop_front();
        chk(pc_o == e.pc, e.tag, "pc", pc_o, e.pc);
        chk(cause_o == e.cause, e.tag, "cause", cause_o, e.cause);
        chk(epc_o == e.epc, e.tag, "epc", epc_o, e.epc);
        chk(eepc_o == e.eepc, e.tag, "error_epc", eepc_o, e.eepc);
        chk({27'b0, exl_o, erl_o, bev_o, nmi_o, sr_o} == e.st, e.tag, "status",
            {27'b0, exl_o, erl_o, bev_o, nmi_o, sr_o}, e.st);
        chk(bva_o == e.bva && ctx_o == e.ctx && ehi_o == e.ehi, e.tag, "bva/ctx/ehi",
            bva_o ^ ctx_o ^ ehi_o, e.bva ^ e.ctx ^ e.ehi);
      end
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual running expected done");
    finish_run();
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    // R12 reset state
    chk({redirect_o, exl_o, erl_o, bev_o, nmi_o, sr_o} == 0 && pc_o == 0 && cause_o == 0 &&
        epc_o == 0 && eepc_o == 0 && bva_o == 0 && ctx_o == 0 && ehi_o == 0,
        "R12", "reset outputs", pc_o | cause_o | epc_o, 0);
    rst_n = 1;
    @(negedge clk);

    // R1 R3 R6: basic entry, EBase-derived base
    ebase = 32'h8000_03FF;
    fire(KIND_SYS, 0, 32'h0000_1000, 0, 0, 0, 0, "R1_R3_R6 sys");
    do_eret("R11 eret exl");
    // R6: delay slot, then nested with EXL set
    fire(KIND_BP, 0, 32'h0000_2004, 1, 0, 0, 0, "R6 bp delay");
    fire(KIND_RI, 0, 32'h0000_3000, 0, 0, 0, 0, "R6 nested hold");
    // R4 refill offset with EXL set, R2 store code
    fire(KIND_TLB_MISS, 1, 32'h0000_3100, 0, 32'h1234_5678, 0, 0, "R4_R2 miss exl set");
    do_eret("R11 eret exl");
    // R4 refill with EXL clear, R9 translation regs
    fire(KIND_TLB_MISS, 0, 32'h0000_3200, 0, 32'hDEAD_BEEF, 0, 0, "R4_R9 refill");
    do_eret("R11 eret");
    fire(KIND_TLB_INV, 0, 32'h40, 0, 32'h7654_3210, 0, 0, "R2 inv load");
    fire(KIND_TLB_DIRTY, 0, 32'h44, 0, 32'h0000_E000, 0, 0, "R2 dirty load");
    fire(KIND_ADDR_ERR, 0, 32'h48, 0, 32'hFFFF_FFFF, 0, 0, "R2_R9 adel");
    fire(KIND_ADDR_ERR, 1, 32'h4C, 0, 32'h0000_2001, 0, 0, "R2 ades");
    fire(KIND_IBE, 0, 32'h50, 0, 32'hAAAA_AAAA, 0, 0, "R9 ibe no mmu write");
    // R8 coprocessor number then retained
    fire(KIND_CPU, 0, 32'h54, 0, 0, 2'd2, 0, "R8 cpu ce");
    fire(KIND_OV, 0, 32'h58, 0, 0, 2'd1, 0, "R8 ce retained");
    fire(KIND_MDMX, 0, 32'h5C, 0, 0, 0, 0, "R1 mdmx");
    fire(KIND_CACHE, 0, 32'h60, 0, 0, 0, 0, "R10 cache ebase");
    // R5 interrupts
    iv = 0; fire(KIND_INTR, 0, 32'h64, 0, 0, 0, 0, "R5 intr plain");
    iv = 1; fire(KIND_INTR, 0, 32'h68, 0, 0, 0, 0, "R5 intr iv");
    vint = 1; vs = 5'd1; pend = 8'b1010_0100; mask = 8'hFF;
    fire(KIND_INTR, 0, 32'h6C, 0, 0, 0, 0, "R5 vec 7");
    mask = 8'b0101_0111; vs = 5'd3;
    fire(KIND_INTR, 0, 32'h70, 0, 0, 0, 0, "R5 vec 2 masked");
    pend = 8'b0000_0001; mask = 8'hFF;
    fire(KIND_INTR, 0, 32'h74, 0, 0, 0, 0, "R5 vec 0");
    vint = 0; iv = 0;
    // R1 unknown kind ignored
    @(negedge clk); exc_valid = 1; kind = 5'd27; pc = 32'h9999_0000;
    @(negedge clk); exc_valid = 0;
    chk(redirect_o == 0 && epc_o == m_epc && cause_o == m_cause() && exl_o == m_exl,
        "R1", "unknown kind ignored", epc_o ^ cause_o, m_epc ^ m_cause());
    // R11 eret concurrent with exception is ignored
    fire(KIND_TR, 0, 32'h78, 0, 0, 0, 1, "R11 eret with exc");
    // R7 NMI, then BEV-based vectors
    fire(KIND_NMI, 0, 32'h0000_5000, 1, 0, 0, 0, "R7 nmi");
    do_eret("R11 eret erl first");
    do_eret("R11 eret exl");
    fire(KIND_SYS, 0, 32'h80, 0, 0, 0, 0, "R3 bev base");
    fire(KIND_CACHE, 0, 32'h84, 0, 0, 0, 0, "R10 cache bev");
    do_reset();
    chk(bev_o == 0 && nmi_o == 0, "R12", "reset clears bev/nmi", {bev_o, nmi_o}, 0);
    fire(KIND_SRESET, 0, 32'h0000_6008, 1, 0, 0, 0, "R7 soft reset");
    repeat (3) @(negedge clk);
    chk(sb.size() == 0, "R11", "all redirects seen", sb.size(), 0);
    finish_run();
  end
endmodule